// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Aggregator

This block gathers interrupt request lines from three banks into a single processor interrupt. Two banks are full 32-line peripheral groups. The third is a small local group of eight lines. The local lines are timer, mailbox, two doorbells, two halted indications and two illegal-access indications. Every line is level-sensitive. A line counts as pending while its input is high and its enable bit is set. Nothing is latched, so a line stops being pending as soon as its input drops.

Software uses a simple valid/address/data port. Each bank has its own pair of enable registers: writing ones to the first sets enable bits, and writing ones to the second clears them. Both addresses read back the bank's current enable mask. Each bank also has a masked pending register.

A summary register lets a handler find the cause with one read in most cases. It holds the local bank directly, one "something pending" flag per peripheral bank, and copies of eleven chosen peripheral lines. Those lines are picked by parameters when the block is elaborated.

The register port is run by a two-state machine. ST_IDLE waits for a request. A read request takes the transition IDLE→RESP, and the read data is captured in that step. ST_RESP presents the response for one cycle. From ST_RESP, the transition RESP→RESP is taken on a back-to-back read, and RESP→IDLE is taken otherwise. Writes never leave ST_IDLE; they take effect at the clock edge that accepts them.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, all enable masks are 0 and `irq` and `rsp_valid` are 0.
- R2: A write to an enable register sets each enable bit whose data bit is 1 and leaves bits written 0 unchanged. The enable registers are at byte 0x10 (peripheral bank 0), 0x14 (peripheral bank 1) and 0x18 (local bank). Only data bits 7:0 apply to the local bank.
- R3: A write to a disable register clears each enable bit whose data bit is 1 and leaves bits written 0 unchanged. The disable registers are at byte 0x20, 0x24 and 0x28, in the same bank order as R2.
- R4: Reading either the enable address or the disable address of a bank returns that bank's current enable mask, zero-extended to 32 bits.
- R5: The pending registers return input AND enable. They are at byte 0x04 (peripheral bank 0), 0x08 (peripheral bank 1) and 0x0C (local bank). A pending bit falls as soon as its input falls, with no latching.
- R6: Summary register (byte 0x00) bits 7:0 equal the local bank's masked pending bits.
- R7: Summary bit 8 is set when any enabled line of peripheral bank 0 is pending. Summary bit 9 does the same for peripheral bank 1.
- R8: Summary bits 14:10 copy the masked pending value of bank-0 lines 7, 9, 10, 18 and 19, in that order. Bits 20:15 copy the masked pending value of bank-1 lines 21, 22, 23, 24, 25 and 30 (global lines 53–57 and 62). Bits 31:21 read 0.
- R9: `irq` is the OR of all masked pending bits, registered, so it changes one clock edge after the pending state changes.
- R10: A read accepted at one edge gives `rsp_valid`=1 for one cycle after that edge, with data sampled at the accepting edge. Unmapped addresses read 0. Writes to addresses other than the six enable/disable registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_bank0 | input | 32 | Level interrupt inputs, peripheral bank 0 |
| src_bank1 | input | 32 | Level interrupt inputs, peripheral bank 1 |
| src_local | input | 8 | Level interrupt inputs, local bank |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address (bits 1:0 ignored) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| irq | output | 1 | Registered interrupt request to processor |

## Verification
The assertions check two rules on every cycle. First, `irq` follows the masked inputs one edge later in both directions. Second, enable masks change only through the enable and disable registers: each write sets or clears exactly the bits written as ones, and a cycle without such a write leaves the masks stable. They also check that a response appears only after a read request. The read-back values need the bench's directed scenarios: the summary layout, the shortcut positions, dropping pending bits with no latch, the zero-extended local bank, unmapped reads and ignored writes.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } port_state_t;

    // word addresses (byte address >> 2)
    localparam logic [5:0] W_SUMMARY = 6'h00;
    localparam logic [5:0] W_PEND_B0 = 6'h01;
    localparam logic [5:0] W_PEND_B1 = 6'h02;
    localparam logic [5:0] W_PEND_LC = 6'h03;
    localparam logic [5:0] W_EN_B0   = 6'h04;
    localparam logic [5:0] W_EN_B1   = 6'h05;
    localparam logic [5:0] W_EN_LC   = 6'h06;
    localparam logic [5:0] W_DIS_B0  = 6'h08;
    localparam logic [5:0] W_DIS_B1  = 6'h09;
    localparam logic [5:0] W_DIS_LC  = 6'h0A;

    localparam int NUM_BANKS = 3;

endpackage

// File: rtl/pic_bank.sv
module pic_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wmask,
    output logic [W-1:0] en,
    output logic [W-1:0] pend
);

    logic [W-1:0] set_bits;
    logic [W-1:0] clr_bits;

    always_comb begin
        set_bits = set_we ? wmask : '0;
        clr_bits = clr_we ? wmask : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= '0;
        end else begin
            en <= (en | set_bits) & ~clr_bits;
        end
    end

    // level-sensitive: no latching of the source
    assign pend = src & en;

endmodule

// File: rtl/pic_summary.sv
module pic_summary #(
    parameter int DATA_W = 32,
    parameter int P_W    = 32,
    parameter int L_W    = 8,
    parameter int N_SC0  = 5,
    parameter int N_SC1  = 6,
    parameter logic [N_SC0*8-1:0] SC0_IDX = {8'd19, 8'd18, 8'd10, 8'd9, 8'd7},
    parameter logic [N_SC1*8-1:0] SC1_IDX = {8'd30, 8'd25, 8'd24, 8'd23, 8'd22, 8'd21}
) (
    input  logic [P_W-1:0]    pend_b0,
    input  logic [P_W-1:0]    pend_b1,
    input  logic [L_W-1:0]    pend_lc,
    output logic [DATA_W-1:0] summary
);

    localparam int USED_W = L_W + 2 + N_SC0 + N_SC1;
    localparam int PAD_W  = DATA_W - USED_W;

    logic [N_SC0-1:0] sc0_bits;
    logic [N_SC1-1:0] sc1_bits;

    for (genvar i = 0; i < N_SC0; i++) begin : g_sc0
        localparam int IDX = int'(SC0_IDX[i*8 +: 8]);
        assign sc0_bits[i] = pend_b0[IDX];
    end

    for (genvar j = 0; j < N_SC1; j++) begin : g_sc1
        localparam int IDX = int'(SC1_IDX[j*8 +: 8]);
        assign sc1_bits[j] = pend_b1[IDX];
    end

    assign summary = {{PAD_W{1'b0}}, sc1_bits, sc0_bits, |pend_b1, |pend_b0, pend_lc};

endmodule

// File: rtl/pic_regport.sv
module pic_regport
    import pic_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int L_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [DATA_W-1:0]    summary,
    input  logic [DATA_W-1:0]    pend_b0,
    input  logic [DATA_W-1:0]    pend_b1,
    input  logic [L_W-1:0]       pend_lc,
    input  logic [DATA_W-1:0]    en_b0,
    input  logic [DATA_W-1:0]    en_b1,
    input  logic [L_W-1:0]       en_lc,
    output logic [NUM_BANKS-1:0] set_we,
    output logic [NUM_BANKS-1:0] clr_we,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata
);

    localparam int WORD_W = ADDR_W - 2;
    localparam int LPAD_W = DATA_W - L_W;

    port_state_t         state_q;
    port_state_t         state_d;
    logic [WORD_W-1:0]   word;
    logic                rd_req;
    logic                wr_req;
    logic [DATA_W-1:0]   rd_mux;

    assign word   = req_addr[ADDR_W-1:2];
    assign rd_req = req_valid && !req_write;
    assign wr_req = req_valid &&  req_write;

    // write strobes
    always_comb begin
        set_we[0] = wr_req && (word == WORD_W'(W_EN_B0));
        set_we[1] = wr_req && (word == WORD_W'(W_EN_B1));
        set_we[2] = wr_req && (word == WORD_W'(W_EN_LC));
        clr_we[0] = wr_req && (word == WORD_W'(W_DIS_B0));
        clr_we[1] = wr_req && (word == WORD_W'(W_DIS_B1));
        clr_we[2] = wr_req && (word == WORD_W'(W_DIS_LC));
    end

    // read selection
    always_comb begin
        rd_mux = '0;
        if      (word == WORD_W'(W_SUMMARY)) rd_mux = summary;
        else if (word == WORD_W'(W_PEND_B0)) rd_mux = pend_b0;
        else if (word == WORD_W'(W_PEND_B1)) rd_mux = pend_b1;
        else if (word == WORD_W'(W_PEND_LC)) rd_mux = {{LPAD_W{1'b0}}, pend_lc};
        else if (word == WORD_W'(W_EN_B0) || word == WORD_W'(W_DIS_B0)) rd_mux = en_b0;
        else if (word == WORD_W'(W_EN_B1) || word == WORD_W'(W_DIS_B1)) rd_mux = en_b1;
        else if (word == WORD_W'(W_EN_LC) || word == WORD_W'(W_DIS_LC)) rd_mux = {{LPAD_W{1'b0}}, en_lc};
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_rdata <= '0;
        else if (rd_req) rsp_rdata <= rd_mux;
    end

    assign rsp_valid = (state_q == ST_RESP);

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import pic_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int P_W    = 32,
    parameter int L_W    = 8,
    parameter int N_SC0  = 5,
    parameter int N_SC1  = 6,
    parameter logic [N_SC0*8-1:0] SC0_IDX = {8'd19, 8'd18, 8'd10, 8'd9, 8'd7},
    parameter logic [N_SC1*8-1:0] SC1_IDX = {8'd30, 8'd25, 8'd24, 8'd23, 8'd22, 8'd21}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [P_W-1:0]    src_bank0,
    input  logic [P_W-1:0]    src_bank1,
    input  logic [L_W-1:0]    src_local,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq
);

    logic [P_W-1:0]       en_b0, en_b1, pend_b0, pend_b1;
    logic [L_W-1:0]       en_lc, pend_lc;
    logic [NUM_BANKS-1:0] set_we, clr_we;
    logic [DATA_W-1:0]    summary;

    pic_bank #(.W(P_W)) u_bank0 (
        .clk(clk), .rst_n(rst_n), .src(src_bank0),
        .set_we(set_we[0]), .clr_we(clr_we[0]), .wmask(req_wdata[P_W-1:0]),
        .en(en_b0), .pend(pend_b0)
    );

    pic_bank #(.W(P_W)) u_bank1 (
        .clk(clk), .rst_n(rst_n), .src(src_bank1),
        .set_we(set_we[1]), .clr_we(clr_we[1]), .wmask(req_wdata[P_W-1:0]),
        .en(en_b1), .pend(pend_b1)
    );

    pic_bank #(.W(L_W)) u_local (
        .clk(clk), .rst_n(rst_n), .src(src_local),
        .set_we(set_we[2]), .clr_we(clr_we[2]), .wmask(req_wdata[L_W-1:0]),
        .en(en_lc), .pend(pend_lc)
    );

    pic_summary #(
        .DATA_W(DATA_W), .P_W(P_W), .L_W(L_W),
        .N_SC0(N_SC0), .N_SC1(N_SC1), .SC0_IDX(SC0_IDX), .SC1_IDX(SC1_IDX)
    ) u_summary (
        .pend_b0(pend_b0), .pend_b1(pend_b1), .pend_lc(pend_lc), .summary(summary)
    );

    pic_regport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .L_W(L_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .summary(summary), .pend_b0(pend_b0), .pend_b1(pend_b1), .pend_lc(pend_lc),
        .en_b0(en_b0), .en_b1(en_b1), .en_lc(en_lc),
        .set_we(set_we), .clr_we(clr_we),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (|pend_b0) | (|pend_b1) | (|pend_lc);
    end

endmodule

// File: rtl/pic_checker.sv
module pic_checker
    import pic_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int P_W    = 32,
    parameter int L_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic [P_W-1:0]    src_bank0,
    input logic [P_W-1:0]    src_bank1,
    input logic [L_W-1:0]    src_local,
    input logic [P_W-1:0]    en_b0,
    input logic [P_W-1:0]    en_b1,
    input logic [L_W-1:0]    en_lc,
    input logic              rsp_valid,
    input logic              irq
);

    localparam int WORD_W = ADDR_W - 2;

    logic any_live;
    logic wr_en0, wr_dis0, touch_b1;

    assign any_live = (|(src_bank0 & en_b0)) | (|(src_bank1 & en_b1)) | (|(src_local & en_lc));
    assign wr_en0   = req_valid && req_write && (req_addr[ADDR_W-1:2] == WORD_W'(W_EN_B0));
    assign wr_dis0  = req_valid && req_write && (req_addr[ADDR_W-1:2] == WORD_W'(W_DIS_B0));
    assign touch_b1 = req_valid && req_write &&
                      ((req_addr[ADDR_W-1:2] == WORD_W'(W_EN_B1)) ||
                       (req_addr[ADDR_W-1:2] == WORD_W'(W_DIS_B1)));

    a_r9_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
        any_live |=> irq);

    a_r9_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
        !any_live |=> !irq);

    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en0 |=> ((en_b0 & $past(req_wdata[P_W-1:0])) == $past(req_wdata[P_W-1:0])));

    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dis0 |=> ((en_b0 & $past(req_wdata[P_W-1:0])) == '0));

    a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !touch_b1 |=> $stable(en_b1));

    a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

endmodule

bind banked_irq_ctrl pic_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .P_W(P_W), .L_W(L_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .src_bank0(src_bank0), .src_bank1(src_bank1), .src_local(src_local),
    .en_b0(en_b0), .en_b1(en_b1), .en_lc(en_lc),
    .rsp_valid(rsp_valid), .irq(irq)
);

// File: tb/tb_banked_irq_ctrl.sv
module tb_banked_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src_bank0, src_bank1;
    logic [7:0]  src_local;
    logic        req_valid, req_write;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    banked_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .src_bank0(src_bank0), .src_bank1(src_bank1), .src_local(src_local),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 rsp_valid", {31'b0, rsp_valid}, 32'd1);
        d = rsp_rdata;
    endtask

    function automatic logic [31:0] exp_sum(input logic [31:0] p0, input logic [31:0] p1,
                                            input logic [7:0] pl);
        logic [31:0] s;
        s = '0;
        s[7:0] = pl;
        s[8]  = |p0;
        s[9]  = |p1;
        s[10] = p0[7];  s[11] = p0[9];  s[12] = p0[10];
        s[13] = p0[18]; s[14] = p0[19];
        s[15] = p1[21]; s[16] = p1[22]; s[17] = p1[23];
        s[18] = p1[24]; s[19] = p1[25]; s[20] = p1[30];
        return s;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        rd(8'h10, d); chk("R1 en bank0", d, 32'h0);
        rd(8'h14, d); chk("R1 en bank1", d, 32'h0);
        rd(8'h18, d); chk("R1 en local", d, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(8'h10, 32'h0000_00F0);
        wr(8'h10, 32'h0000_000F);
        rd(8'h10, d); chk("R2 set accumulates", d, 32'h0000_00FF);
        wr(8'h10, 32'h0);
        rd(8'h10, d); chk("R2 zero write no effect", d, 32'h0000_00FF);
        rd(8'h20, d); chk("R4 read via disable addr", d, 32'h0000_00FF);
        wr(8'h14, 32'h8000_0001);
        rd(8'h24, d); chk("R4 bank1 via disable addr", d, 32'h8000_0001);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, d); chk("R2 local 8 bits", d, 32'h0000_00FF);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        wr(8'h20, 32'h0000_0030);
        rd(8'h10, d); chk("R3 clear bits", d, 32'h0000_00CF);
        wr(8'h20, 32'h0);
        rd(8'h10, d); chk("R3 zero write no effect", d, 32'h0000_00CF);
        wr(8'h28, 32'h0000_000F);
        rd(8'h18, d); chk("R3 local clear", d, 32'h0000_00F0);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        src_bank0 = 32'hFFFF_FFFF;
        rd(8'h04, d); chk("R5 masked bank0", d, 32'h0000_00CF);
        src_bank0 = 32'h0;
        rd(8'h04, d); chk("R5 no latch", d, 32'h0);
        src_bank1 = 32'hFFFF_0000;
        rd(8'h08, d); chk("R5 masked bank1", d, 32'h8000_0000);
        src_bank1 = 32'h0;
        src_local = 8'hFF;
        rd(8'h0C, d); chk("R5 masked local", d, 32'h0000_00F0);
        src_local = 8'h0;
    endtask

    task automatic t_summary();
        logic [31:0] d;
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h18, 32'h0000_00FF);
        src_bank0 = 32'h0000_0088; src_bank1 = 32'h0; src_local = 8'h05;
        rd(8'h00, d); chk("R6 R7 R8 pattern a", d, exp_sum(src_bank0, src_bank1, src_local));
        src_bank0 = 32'h000C_0000; src_bank1 = 32'h4020_0000; src_local = 8'h0;
        rd(8'h00, d); chk("R8 pattern b", d, exp_sum(src_bank0, src_bank1, src_local));
        src_bank0 = 32'h0; src_bank1 = 32'h0000_0020; src_local = 8'h80;
        rd(8'h00, d); chk("R7 bank1 flag only", d, exp_sum(src_bank0, src_bank1, src_local));
        src_bank0 = 32'h0000_0600; src_bank1 = 32'h03C0_0000; src_local = 8'h0;
        rd(8'h00, d); chk("R8 pattern d", d, exp_sum(src_bank0, src_bank1, src_local));
        wr(8'h20, 32'h0000_0080);
        src_bank0 = 32'h0000_0080; src_bank1 = 32'h0;
        rd(8'h00, d); chk("R7 masked line hidden", d, 32'h0);
        wr(8'h10, 32'h0000_0080);
        rd(8'h00, d); chk("R8 line 7 shortcut", d, 32'h0000_0500);
        src_bank0 = 32'h0;
    endtask

    task automatic t_irq();
        @(negedge clk);
        chk("R9 idle low", {31'b0, irq}, 32'd0);
        src_local = 8'h01;
        #1 chk("R9 registered not comb", {31'b0, irq}, 32'd0);
        @(negedge clk);
        chk("R9 rises one edge later", {31'b0, irq}, 32'd1);
        wr(8'h28, 32'h0000_0001);
        chk("R9 still high at disable edge", {31'b0, irq}, 32'd1);
        @(negedge clk);
        chk("R9 falls after disable", {31'b0, irq}, 32'd0);
        src_local = 8'h0;
        src_bank1 = 32'h0000_0100;
        @(negedge clk);
        chk("R9 bank1 drives irq", {31'b0, irq}, 32'd1);
        src_bank1 = 32'h0;
        @(negedge clk);
        chk("R9 drops with input", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_misc();
        logic [31:0] d;
        rd(8'h3C, d); chk("R10 unmapped reads zero", d, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h10, 32'h0000_00FF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h10, d); chk("R10 read-only writes ignored", d, 32'h0000_00FF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        src_bank0 = '0; src_bank1 = '0; src_local = '0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_disable();
        t_pending();
        t_summary();
        t_irq();
        t_misc();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule